// File: doc/BRIEF.md
# Microscaling Block-Scale Fetch and Combine

This block serves the scaled flavour of a matrix multiply-accumulate engine. For one output row it walks the reduction dimension in blocks of BS elements. For every block it fetches a 16-bit scale pair from the image of the mask register. The pair holds two 8-bit exponent-only scales, one for each input operand. The block decodes both scales and adds their unbiased exponents into a single power-of-two exponent. That exponent goes to a downstream accumulator, which applies it as an exact exponent addition, so no rounding is involved. It also raises a NaN flag when either scale holds the reserved all-ones code.

A walk is launched by a one-cycle `start` strobe. With it the caller presents the element width code, the lambda code, the block-size select, the reduction length, the row index and three legality qualifiers. The walk then produces one result per cycle, the last one marked. The pair position advances through the mask image with a stride derived from lambda and the element width. A configuration that scaled operation does not allow is rejected with a one-cycle `illegal` pulse, and no results follow.

An 8-bit scale e means 2^(e-127), and e = 0xFF means NaN. The mask image must be held stable while `busy` is high.

Top module: `mx_scale_fetch`

## Requirements
- R1: After reset, `busy`, `illegal`, `outValid`, `outNan` and `outLast` are 0.
- R2: Scale pair j occupies `v0Img[16j+15:16j]`, with the A scale in bits [7:0] and the B scale in bits [15:8]. For a non-NaN pair, `outExp` is the signed 10-bit value (eA-127)+(eB-127).
- R3: If either byte of the fetched pair is 0xFF, the result has `outNan`=1 and `outExp`=0.
- R4: An accepted walk with reduction length vl yields ceil(vl/BS) results, where BS is 32 for `bsSel`=0 and 16 for `bsSel`=1. The results come on consecutive cycles, starting two clock edges after the start edge. Only the final result has `outLast`=1. `busy` is high from the edge after the start edge until that final result is issued.
- R5: The result for block s uses pair index (rowIdx·Rs + s) mod (VLEN/16). Here Rs = lambda·SEW/16, lambda = 2^`lambdaSel` and SEW = 8·2^`sewSel` (`sewSel` 0..3 gives 8, 16, 32, 64).
- R6: A start with SEW·lambda below 16 (`sewSel`=0 and `lambdaSel`=0) pulses `illegal` for one cycle, visible after the start edge, and yields no results. SEW 8 with lambda 2 is legal.
- R7: A start with `overlapV0`=1 is rejected the same way as in R6.
- R8: A start with `intInput`=1 and either `fmtA` or `fmtB` equal to 1 is rejected the same way as in R6. With `intInput`=0 the two format flags do not affect legality.
- R9: A legal start with vl=0 yields no results, no `illegal` pulse, and leaves `busy` low.
- R10: A `start` strobe that arrives while `busy` is high is ignored. The running walk completes unchanged and no further results follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch strobe for one row walk |
| sewSel | input | 2 | Element width code, SEW = 8·2^sewSel |
| lambdaSel | input | 3 | Lambda code, lambda = 2^lambdaSel |
| bsSel | input | 1 | Block size select: 0 gives 32, 1 gives 16 |
| vl | input | VL_W | Reduction length in elements |
| rowIdx | input | ROW_W | Output row index |
| v0Img | input | VLEN | Mask register image holding the scale pairs |
| overlapV0 | input | 1 | An operand register group overlaps the mask register |
| intInput | input | 1 | Integer-input scaled operation |
| fmtA | input | 1 | Format flag of operand A |
| fmtB | input | 1 | Format flag of operand B |
| busy | output | 1 | Walk in progress |
| illegal | output | 1 | One-cycle pulse: start rejected |
| outValid | output | 1 | Result strobe |
| outExp | output | 10 | Combined signed exponent |
| outNan | output | 1 | Result is canonical NaN |
| outLast | output | 1 | Final block of the walk |

## Verification
Two functions can fall in the same cycle. The first case is a NaN decode on the very last block, where `outNan` and `outLast` must rise together. The bench provokes it by placing 0xFF in the B byte of exactly the pair addressed by the final block. The second case is a fresh `start` landing while the walk is still emitting. For this the bench raises `start` with different parameters in the cycle right after launch. It then judges that the result count, each pair address and the end of the walk all still match the first command.

// File: rtl/mx_scale_fetch_pkg.sv
package mx_scale_fetch_pkg;

  localparam int SCALE_W    = 8;
  localparam int PAIR_W     = 2 * SCALE_W;
  localparam int EXP_W      = 10;
  localparam int SCALE_BIAS = 127;
  localparam logic [SCALE_W-1:0] SCALE_NAN = 8'hFF;

  typedef struct packed {
    logic load;   // capture the walk's first pair address
    logic emit;   // decode current pair, advance address
    logic last;   // this emission closes the walk
  } msfStrobe_t;

endpackage

// File: rtl/mx_scale_fetch_ctrl.sv
module mx_scale_fetch_ctrl
  import mx_scale_fetch_pkg::*;
#(
  parameter int VL_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [1:0]      sewSel,
  input  logic [2:0]      lambdaSel,
  input  logic            bsSel,
  input  logic [VL_W-1:0] vl,
  input  logic            overlapV0,
  input  logic            intInput,
  input  logic            fmtA,
  input  logic            fmtB,
  output msfStrobe_t      strobe,
  output logic            busy,
  output logic            illegal
);

  localparam int SUM_W = VL_W + 1;
  localparam int BLK_W = VL_W - 3;

  typedef enum logic {IDLE, RUN} state_t;

  state_t          stateQ;
  logic [BLK_W-1:0] leftQ;
  logic [BLK_W-1:0] blockCount;
  logic [SUM_W-1:0] padSum;
  logic             badCfg;
  logic             accept;
  logic             illegalQ;

  // number of blocks = ceil(vl / BS)
  always_comb begin
    if (bsSel) begin
      padSum     = SUM_W'(vl) + SUM_W'(15);
      blockCount = BLK_W'(padSum >> 4);
    end else begin
      padSum     = SUM_W'(vl) + SUM_W'(31);
      blockCount = BLK_W'(padSum >> 5);
    end
  end

  assign badCfg = ((sewSel == 2'd0) && (lambdaSel == 3'd0))
                | overlapV0
                | (intInput & (fmtA | fmtB));

  assign accept = start && (stateQ == IDLE);

  always_comb begin
    strobe      = '0;
    strobe.load = accept && !badCfg && (blockCount != '0);
    strobe.emit = (stateQ == RUN);
    strobe.last = (stateQ == RUN) && (leftQ == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= IDLE;
      leftQ    <= '0;
      illegalQ <= 1'b0;
    end else begin
      illegalQ <= accept && badCfg;
      case (stateQ)
        IDLE: begin
          if (strobe.load) begin
            stateQ <= RUN;
            leftQ  <= blockCount - BLK_W'(1);
          end
        end
        RUN: begin
          if (leftQ == '0) stateQ <= IDLE;
          else             leftQ  <= leftQ - BLK_W'(1);
        end
        default: stateQ <= IDLE;
      endcase
    end
  end

  assign busy    = (stateQ == RUN);
  assign illegal = illegalQ;

endmodule

// File: rtl/mx_scale_fetch_dp.sv
module mx_scale_fetch_dp
  import mx_scale_fetch_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int ROW_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  msfStrobe_t              strobe,
  input  logic [1:0]              sewSel,
  input  logic [2:0]              lambdaSel,
  input  logic [ROW_W-1:0]        rowIdx,
  input  logic [VLEN-1:0]         v0Img,
  output logic                    outValid,
  output logic signed [EXP_W-1:0] outExp,
  output logic                    outNan,
  output logic                    outLast
);

  localparam int PAIRS  = VLEN / PAIR_W;
  localparam int ADDR_W = $clog2(PAIRS);
  localparam int BASE_W = ROW_W + 10;

  logic [PAIR_W-1:0] pairArr [PAIRS];
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] loadAddr;
  logic [3:0]        shiftAmt;
  logic [PAIR_W-1:0] curPair;
  logic [SCALE_W-1:0] scaleA, scaleB;
  logic              pairNan;
  logic signed [EXP_W-1:0] pairExp;

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    assign pairArr[j] = v0Img[j*PAIR_W +: PAIR_W];
  end

  // stride = lambda*SEW/16 = 2^(lambdaSel + sewSel - 1)
  assign shiftAmt = 4'(sewSel) + 4'(lambdaSel) - 4'd1;
  assign loadAddr = ADDR_W'(BASE_W'(rowIdx) << shiftAmt);

  assign curPair = pairArr[addrQ];
  assign scaleA  = curPair[SCALE_W-1:0];
  assign scaleB  = curPair[PAIR_W-1:SCALE_W];
  assign pairNan = (scaleA == SCALE_NAN) || (scaleB == SCALE_NAN);
  assign pairExp = $signed({2'b00, scaleA}) + $signed({2'b00, scaleB})
                 - EXP_W'(2 * SCALE_BIAS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      outValid <= 1'b0;
      outExp   <= '0;
      outNan   <= 1'b0;
      outLast  <= 1'b0;
    end else begin
      outValid <= strobe.emit;
      outLast  <= strobe.emit && strobe.last;
      if (strobe.load) begin
        addrQ <= loadAddr;
      end else if (strobe.emit) begin
        addrQ <= addrQ + ADDR_W'(1);
      end
      if (strobe.emit) begin
        outNan <= pairNan;
        outExp <= pairNan ? '0 : pairExp;
      end
    end
  end

endmodule

// File: rtl/mx_scale_fetch.sv
module mx_scale_fetch
  import mx_scale_fetch_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int ROW_W = 8,
  parameter int VL_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [1:0]              sewSel,
  input  logic [2:0]              lambdaSel,
  input  logic                    bsSel,
  input  logic [VL_W-1:0]         vl,
  input  logic [ROW_W-1:0]        rowIdx,
  input  logic [VLEN-1:0]         v0Img,
  input  logic                    overlapV0,
  input  logic                    intInput,
  input  logic                    fmtA,
  input  logic                    fmtB,
  output logic                    busy,
  output logic                    illegal,
  output logic                    outValid,
  output logic signed [EXP_W-1:0] outExp,
  output logic                    outNan,
  output logic                    outLast
);

  msfStrobe_t strobe;

  mx_scale_fetch_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sewSel(sewSel),
    .lambdaSel(lambdaSel), .bsSel(bsSel), .vl(vl),
    .overlapV0(overlapV0), .intInput(intInput), .fmtA(fmtA), .fmtB(fmtB),
    .strobe(strobe), .busy(busy), .illegal(illegal)
  );

  mx_scale_fetch_dp #(.VLEN(VLEN), .ROW_W(ROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sewSel(sewSel),
    .lambdaSel(lambdaSel), .rowIdx(rowIdx), .v0Img(v0Img),
    .outValid(outValid), .outExp(outExp), .outNan(outNan), .outLast(outLast)
  );

endmodule

// File: rtl/mx_scale_fetch_chk.sv
module mx_scale_fetch_chk (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             illegal,
  input logic             outValid,
  input logic signed [9:0] outExp,
  input logic             outNan,
  input logic             outLast
);

  // R3
  nan_zero_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outNan) |-> (outExp == 10'sd0));

  // R2
  exp_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outNan) |-> ((outExp >= -10'sd254) && (outExp <= 10'sd254)));

  // R4
  last_is_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R4
  valid_follows_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(busy));

  // R4
  last_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> !busy);

  // R6
  illegal_no_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!busy && !outValid));

  // R6
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> !illegal);

endmodule

bind mx_scale_fetch mx_scale_fetch_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .illegal(illegal),
  .outValid(outValid), .outExp(outExp), .outNan(outNan), .outLast(outLast)
);

// File: tb/mx_scale_fetch_tb.sv
module mx_scale_fetch_tb;

  localparam int VLEN  = 256;
  localparam int PAIRS = VLEN / 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] sewSel = '0;
  logic [2:0] lambdaSel = '0;
  logic bsSel = 1'b0;
  logic [15:0] vl = '0;
  logic [7:0] rowIdx = '0;
  logic [VLEN-1:0] v0Img = '0;
  logic overlapV0 = 1'b0, intInput = 1'b0, fmtA = 1'b0, fmtB = 1'b0;
  logic busy, illegal, outValid, outNan, outLast;
  logic signed [9:0] outExp;

  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  mx_scale_fetch u_dut (
    .clk(clk), .rstN(rstN), .start(start), .sewSel(sewSel),
    .lambdaSel(lambdaSel), .bsSel(bsSel), .vl(vl), .rowIdx(rowIdx),
    .v0Img(v0Img), .overlapV0(overlapV0), .intInput(intInput),
    .fmtA(fmtA), .fmtB(fmtB), .busy(busy), .illegal(illegal),
    .outValid(outValid), .outExp(outExp), .outNan(outNan), .outLast(outLast)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setPair(input int j, input int ea, input int eb);
    v0Img[j*16 +: 8]   = 8'(ea);
    v0Img[j*16+8 +: 8] = 8'(eb);
  endtask

  function automatic int refAddr(input int row, input int lam, input int sew, input int s);
    int shift;
    shift = lam + sew - 1;
    return ((row << shift) + s) % PAIRS;
  endfunction

  task automatic runOp(input int row, input int lam, input int sew, input int bs,
                       input int len, input int ovl, input int intIn,
                       input int fa, input int fb, input int extra, input string req);
    bit expIll;
    int nBlk, a, ea, eb, expE;
    bit expN;
    expIll = ((sew == 0) && (lam == 0)) || (ovl != 0) || ((intIn != 0) && ((fa != 0) || (fb != 0)));
    nBlk = expIll ? 0 : (bs != 0 ? (len + 15) / 16 : (len + 31) / 32);
    @(negedge clk);
    rowIdx = 8'(row); lambdaSel = 3'(lam); sewSel = 2'(sew); bsSel = 1'(bs);
    vl = 16'(len); overlapV0 = 1'(ovl); intInput = 1'(intIn);
    fmtA = 1'(fa); fmtB = 1'(fb); start = 1'b1;
    @(negedge clk);
    start = 1'(extra);
    if (extra != 0) begin
      rowIdx = 8'(row + 5); lambdaSel = 3'd1; sewSel = 2'd0; bsSel = 1'b1;
      vl = 16'd200;
    end
    chk(illegal == expIll, req, "illegal pulse", illegal, expIll);
    chk(busy == (nBlk > 0), "R4", "busy after start", busy, nBlk > 0);
    chk(!outValid, "R4", "no result one edge after start", outValid, 0);
    for (int i = 0; i <= nBlk; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (i < nBlk) begin
        a  = refAddr(row, lam, sew, i);
        ea = int'(v0Img[a*16 +: 8]);
        eb = int'(v0Img[a*16+8 +: 8]);
        expN = (ea == 255) || (eb == 255);
        expE = expN ? 0 : (ea - 127) + (eb - 127);
        chk(outValid, "R4", "result strobe", outValid, 1);
        chk(outNan == expN, "R3", "nan flag", outNan, expN);
        chk(int'(outExp) == expE, "R2", "combined exponent (R5 addressing)", outExp, expE);
        chk(outLast == (i == nBlk - 1), "R4", "last marker", outLast, i == nBlk - 1);
      end else begin
        chk(!outValid && !busy, (extra != 0) ? "R10" : req, "walk ended",
            {outValid, busy}, 0);
      end
    end
    if (extra != 0) begin
      repeat (3) begin
        @(negedge clk);
        chk(!outValid && !busy, "R10", "ignored start produced nothing", outValid, 0);
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    nRun++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int j = 0; j < PAIRS; j++) setPair(j, 127 + j, 127 - 2 * j);
    setPair(14, 254, 254);
    setPair(15, 0, 0);
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(!busy && !illegal && !outValid && !outNan && !outLast, "R1", "reset outputs",
        {busy, illegal, outValid, outNan, outLast}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !outValid, "R1", "idle after reset", {busy, outValid}, 0);

    // R2 R4: stride 1, BS 32, two blocks
    runOp(0, 1, 0, 0, 64, 0, 0, 0, 0, 0, "R2");
    // R4: BS 16, vl 33 -> three blocks
    runOp(2, 0, 1, 1, 33, 0, 0, 0, 0, 0, "R4");
    // R2 extremes at pairs 14 and 15
    runOp(14, 0, 1, 1, 32, 0, 0, 0, 0, 0, "R2");
    // R5: stride 8, row 3 -> pair 8, then wrap
    runOp(3, 2, 2, 0, 96, 0, 0, 0, 0, 0, "R5");
    runOp(1, 3, 3, 1, 40, 0, 0, 0, 0, 0, "R5");
    // R3: NaN on final block (pair 5 via row 4, stride 1, second block)
    setPair(5, 130, 255);
    runOp(4, 0, 1, 1, 32, 0, 0, 0, 0, 0, "R3");
    setPair(6, 255, 100);
    runOp(6, 1, 0, 0, 1, 0, 0, 0, 0, 0, "R3");
    // R6
    runOp(0, 0, 0, 0, 64, 0, 0, 0, 0, 0, "R6");
    runOp(0, 1, 0, 0, 64, 0, 0, 0, 0, 0, "R6");
    // R7
    runOp(0, 1, 1, 0, 64, 1, 0, 0, 0, 0, "R7");
    // R8
    runOp(0, 1, 1, 0, 64, 0, 1, 1, 0, 0, "R8");
    runOp(0, 1, 1, 0, 64, 0, 1, 0, 1, 0, "R8");
    runOp(0, 1, 1, 0, 64, 0, 0, 1, 1, 0, "R8");
    runOp(0, 1, 1, 0, 64, 0, 1, 0, 0, 0, "R8");
    // R9
    runOp(0, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R10
    runOp(2, 1, 1, 0, 96, 0, 0, 0, 0, 1, "R10");

    // randomized walks
    for (int t = 0; t < 40; t++) begin
      int lam, sew;
      for (int w = 0; w < VLEN / 32; w++) v0Img[w*32 +: 32] = $urandom;
      if (($urandom % 3) == 0) v0Img[($urandom % PAIRS) * 16 + 8 * ($urandom % 2) +: 8] = 8'hFF;
      lam = $urandom % 4;
      sew = $urandom % 4;
      if (lam == 0 && sew == 0) lam = 1;
      runOp($urandom % 256, lam, sew, $urandom % 2, 1 + ($urandom % 200),
            0, 0, 0, 0, 0, "R5");
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule